// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block works out the order in which word addresses are visited during a synchronous burst read from a memory array. When a burst is started, it captures four things:

- the first word address;
- a three-bit length code;
- a select for sequential or interleaved order;
- a select for wrapping inside an aligned block or running past it.

Each advance strobe after that moves the registered address output to the next word of the burst. A fixed-length burst stops by itself after its last word. A continuous burst runs until the next start.

Some configurations have no defined order. For these the block raises an illegal flag and does not start a burst. Alongside each new address it also pulses two markers. One fires when the step entered a different 4-word group, and the other when it entered a different 16-word group. A downstream controller uses these markers to decide where to insert wait states.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset, `addr_out` is 0 and `active`, `illegal`, `cross4` and `cross16` are all low.
- R2: A `start` with a legal configuration takes effect on the next clock edge. After that edge, `addr_out` equals `start_addr`, `active` is high and `illegal` is low. `start` wins over `advance` in the same cycle, and a new `start` restarts a burst that is already running.
- R3: Length codes are: 3'b001 for 4 words, 3'b010 for 8 words, 3'b011 for 16 words, and 3'b111 for continuous. A fixed-length burst drops `active` on the same edge that produces its last word. An `advance` while `active` is low leaves every output unchanged.
- R4: In sequential order with wrap (`interleave`=0, `no_wrap`=0), word n has the low log2(L) bits equal to (start + n) mod L. The upper bits stay equal to those of the start address.
- R5: In sequential order with `no_wrap`=1, each advance adds 1 to the whole address. This carries across the block boundary.
- R6: When the start address is a multiple of L, wrap and no-wrap give the same sequence.
- R7: In interleaved order (`interleave`=1, wrap, fixed length), word n has the low log2(L) bits equal to the start's low bits XOR n. The upper bits are held.
- R8: A continuous burst adds 1 on every advance and never ends by itself. It rolls over from all ones to zero.
- R9: The following configurations are illegal: `interleave`=1 together with continuous length; `interleave`=1 together with `no_wrap`=1; and any length code other than 001, 010, 011 or 111. Starting with one of these sets `illegal` and clears `active`, while `addr_out` holds. The next legal start clears `illegal`.
- R10: `cross4` is high for exactly the one cycle after an accepted advance that changed `addr_out` bits [ADDR_W-1:2]. It is low otherwise.
- R11: `cross16` is high for exactly the one cycle after an accepted advance that changed `addr_out` bits [ADDR_W-1:4]. It is low otherwise, and it is never high without `cross4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst with the configuration presented this cycle |
| start_addr | input | ADDR_W | First word address of the burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved order, 0 sequential |
| no_wrap | input | 1 | 1 lets sequential bursts run past the block boundary |
| advance | input | 1 | Step to the next word of the running burst |
| addr_out | output | ADDR_W | Current word address (registered) |
| active | output | 1 | A burst is running and accepts advances |
| illegal | output | 1 | The last start carried an illegal configuration |
| cross4 | output | 1 | Last step entered a new 4-word group |
| cross16 | output | 1 | Last step entered a new 16-word group |

## Verification
Bursts are run from misaligned starts in each legal order.

- An 8-word sequential wrap from offset 5 exposes the modulo fold and the 4-group marker it raises.
- A 4-word no-wrap from offset 14 must carry into the next 16-word group, which separates it from wrap.
- Interleaved runs from offsets 3 (8 words) and 5 (16 words) make the XOR order differ from any additive one.
- An aligned start run in both wrap modes must give identical lists.
- A continuous run started two below the top of the address space shows the rollover and the 16-group marker.
- Each illegal combination, an advance after the end of a burst, and a restart with `start` and `advance` raised together check that held state stays put.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam logic [2:0] LEN_CODE_4    = 3'b001;
  localparam logic [2:0] LEN_CODE_8    = 3'b010;
  localparam logic [2:0] LEN_CODE_16   = 3'b011;
  localparam logic [2:0] LEN_CODE_CONT = 3'b111;

  localparam int unsigned LOW_W = 4;  // widest block is 16 words

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,  // +1 over the full address
    MODE_WRAP   = 2'd1,  // +n folded inside the block
    MODE_XOR    = 2'd2   // start ^ n inside the block
  } seq_mode_e;

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_seq_pkg::*;
(
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             no_wrap,
  output logic             legal,
  output logic             continuous,
  output logic [LOW_W-1:0] low_mask,
  output seq_mode_e        mode
);

  logic known_len;

  always_comb begin
    known_len  = 1'b1;
    continuous = 1'b0;
    low_mask   = '0;
    unique case (len_code)
      LEN_CODE_4:    low_mask = 4'b0011;
      LEN_CODE_8:    low_mask = 4'b0111;
      LEN_CODE_16:   low_mask = 4'b1111;
      LEN_CODE_CONT: begin
        low_mask   = 4'b1111;
        continuous = 1'b1;
      end
      default:       known_len = 1'b0;
    endcase

    legal = known_len && !(interleave && (continuous || no_wrap));

    if (interleave)                mode = MODE_XOR;
    else if (no_wrap || continuous) mode = MODE_LINEAR;
    else                           mode = MODE_WRAP;
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  input  logic [LOW_W-1:0]  low_mask,
  input  logic [LOW_W-1:0]  step,
  input  seq_mode_e         mode,
  output logic [ADDR_W-1:0] nxt
);

  localparam int unsigned PAD_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] mask_ext;
  logic [ADDR_W-1:0] step_ext;

  assign mask_ext = {{PAD_W{1'b0}}, low_mask};
  assign step_ext = {{PAD_W{1'b0}}, step};

  always_comb begin
    unique case (mode)
      MODE_XOR:  nxt = (base & ~mask_ext) | ((base ^ step_ext) & mask_ext);
      MODE_WRAP: nxt = (base & ~mask_ext) | ((base + step_ext) & mask_ext);
      default:   nxt = cur + {{(ADDR_W-1){1'b0}}, 1'b1};
    endcase
  end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        len_code,
  input  logic              interleave,
  input  logic              no_wrap,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr_out,
  output logic              active,
  output logic              illegal,
  output logic              cross4,
  output logic              cross16
);

  localparam int unsigned PAD_W = ADDR_W - LOW_W;

  logic             legal_d;
  logic             cont_d;
  logic [LOW_W-1:0] mask_d;
  seq_mode_e        mode_d;

  logic [ADDR_W-1:0] base_q;
  logic [LOW_W-1:0]  mask_q;
  logic [LOW_W-1:0]  cnt_q;
  logic              cont_q;
  seq_mode_e         mode_q;

  logic [LOW_W-1:0]  step_w;
  logic [ADDR_W-1:0] nxt_addr;
  logic              last_step;
  logic              take_adv;

  burst_cfg_decode u_dec (
    .len_code   (len_code),
    .interleave (interleave),
    .no_wrap    (no_wrap),
    .legal      (legal_d),
    .continuous (cont_d),
    .low_mask   (mask_d),
    .mode       (mode_d)
  );

  assign step_w    = cnt_q + 4'd1;
  assign last_step = !cont_q && (step_w == mask_q);
  assign take_adv  = advance && active;

  burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .cur      (addr_out),
    .base     (base_q),
    .low_mask (mask_q),
    .step     (step_w),
    .mode     (mode_q),
    .nxt      (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      active   <= 1'b0;
      illegal  <= 1'b0;
      cross4   <= 1'b0;
      cross16  <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
      cont_q   <= 1'b0;
      mode_q   <= MODE_LINEAR;
    end else begin
      cross4  <= 1'b0;
      cross16 <= 1'b0;
      if (start) begin
        if (legal_d) begin
          addr_out <= start_addr;
          base_q   <= start_addr;
          mask_q   <= mask_d;
          cont_q   <= cont_d;
          mode_q   <= mode_d;
          cnt_q    <= '0;
          active   <= 1'b1;
          illegal  <= 1'b0;
        end else begin
          active  <= 1'b0;
          illegal <= 1'b1;
        end
      end else if (take_adv) begin
        addr_out <= nxt_addr;
        cnt_q    <= step_w;
        cross4   <= (nxt_addr[ADDR_W-1:2] != addr_out[ADDR_W-1:2]);
        cross16  <= (nxt_addr[ADDR_W-1:4] != addr_out[ADDR_W-1:4]);
        if (last_step) active <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [ADDR_W-1:0] mask_ext;
  assign mask_ext = {{PAD_W{1'b0}}, mask_q};

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (addr_out == '0 && !active && !illegal && !cross4 && !cross16));

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start && legal_d) |=> (active && !illegal && addr_out == $past(start_addr)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!start && !(advance && active)) |=> $stable(addr_out));

  p_block_stay_r4: assert property (@(posedge clk) disable iff (rst)
    (active && advance && !start && mode_q != MODE_LINEAR)
      |=> ((addr_out & ~mask_ext) == ($past(addr_out) & ~$past(mask_ext))));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
    (active && advance && !start && mode_q == MODE_LINEAR)
      |=> (addr_out == $past(addr_out) + {{(ADDR_W-1){1'b0}}, 1'b1}));

  p_illegal_idle_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !active);

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(illegal) |-> $stable(addr_out));

  p_cross_cause_r10: assert property (@(posedge clk) disable iff (rst)
    cross4 |-> ($past(advance) && $past(active) && !$past(start)));

  p_cross_nest_r11: assert property (@(posedge clk) disable iff (rst)
    cross16 |-> cross4);

endmodule

// File: tb/burst_seq_gen_test.sv
`timescale 1ns/1ps
module burst_seq_gen_test;

  localparam int AW = 16;

  typedef struct {
    logic [AW-1:0] a;
    logic          act;
    logic          ill;
    logic          c4;
    logic          c16;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0]    len_code = 3'b000;
  logic          interleave = 1'b0;
  logic          no_wrap = 1'b0;
  logic          advance = 1'b0;
  logic [AW-1:0] addr_out;
  logic          active, illegal, cross4, cross16;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];

  // reference state (from the requirements)
  logic [AW-1:0] m_base = '0, m_addr = '0;
  logic          m_act = 1'b0, m_ill = 1'b0, m_il = 1'b0, m_nw = 1'b0;
  int            m_len = 0, m_n = 0;   // m_len 0 = continuous

  always #2.5 clk = ~clk;  // 200 MHz

  burst_seq_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .len_code(len_code), .interleave(interleave), .no_wrap(no_wrap),
    .advance(advance), .addr_out(addr_out), .active(active),
    .illegal(illegal), .cross4(cross4), .cross16(cross16)
  );

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b001: return 4;
      3'b010: return 8;
      3'b011: return 16;
      3'b111: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [AW-1:0] ref_addr(input int n);
    logic [AW-1:0] m;
    if (m_len == 0) return m_base + AW'(n);
    m = AW'(m_len - 1);
    if (m_il)      return (m_base & ~m) | ((m_base ^ AW'(n)) & m);
    if (m_nw)      return m_base + AW'(n);
    return (m_base & ~m) | ((m_base + AW'(n)) & m);
  endfunction

  // driver: one call per clock, pushes what the outputs must be after the edge
  task automatic cyc(input logic s, input logic adv, input logic [AW-1:0] sa,
                     input logic [2:0] code, input logic il, input logic nw,
                     input string tag);
    exp_t e;
    logic [AW-1:0] prev;
    int L;
    @(negedge clk);
    start = s; advance = adv; start_addr = sa;
    len_code = code; interleave = il; no_wrap = nw;
    e.c4 = 1'b0; e.c16 = 1'b0;
    if (s) begin
      L = len_of(code);
      if (L >= 0 && !(il && (L == 0 || nw))) begin
        m_base = sa; m_addr = sa; m_len = L; m_il = il; m_nw = nw;
        m_n = 0; m_act = 1'b1; m_ill = 1'b0;
      end else begin
        m_act = 1'b0; m_ill = 1'b1;
      end
    end else if (adv && m_act) begin
      prev   = m_addr;
      m_n    = m_n + 1;
      m_addr = ref_addr(m_n);
      e.c4   = (prev >> 2) != (m_addr >> 2);
      e.c16  = (prev >> 4) != (m_addr >> 4);
      if (m_len != 0 && m_n == m_len - 1) m_act = 1'b0;
    end
    e.a = m_addr; e.act = m_act; e.ill = m_ill; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic burst(input logic [AW-1:0] sa, input logic [2:0] code,
                       input logic il, input logic nw, input int advs, input string tag);
    cyc(1'b1, 1'b0, sa, code, il, nw, tag);
    for (int i = 0; i < advs; i++) cyc(1'b0, 1'b1, '0, 3'b000, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares after each edge, away from it
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (addr_out !== e.a || active !== e.act || illegal !== e.ill ||
          cross4 !== e.c4 || cross16 !== e.c16) begin
        fails++;
        $display("FAIL %s: got addr=%h act=%b ill=%b c4=%b c16=%b, expected addr=%h act=%b ill=%b c4=%b c16=%b",
                 e.tag, addr_out, active, illegal, cross4, cross16,
                 e.a, e.act, e.ill, e.c4, e.c16);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    cyc(1'b0, 1'b0, '0, 3'b000, 1'b0, 1'b0, "R1 reset state");
    cyc(1'b0, 1'b1, '0, 3'b000, 1'b0, 1'b0, "R3 advance while idle");
    // R4 sequential wrap, 8 words from offset 5; R10 marker on 7->0
    burst(16'h0105, 3'b010, 1'b0, 1'b0, 7, "R4 R10 seq wrap 8");
    cyc(1'b0, 1'b1, '0, 3'b000, 1'b0, 1'b0, "R3 advance after end ignored");
    // R5 no-wrap 4 words from 0x0E, R11 crossing at 0x0F->0x10
    burst(16'h000E, 3'b001, 1'b0, 1'b1, 3, "R5 R11 seq no-wrap 4");
    // R6 aligned start, both wrap settings
    burst(16'h0020, 3'b001, 1'b0, 1'b0, 3, "R6 aligned wrap");
    burst(16'h0020, 3'b001, 1'b0, 1'b1, 3, "R6 aligned no-wrap");
    // R4 sequential wrap 16 words from 0x4007
    burst(16'h4007, 3'b011, 1'b0, 1'b0, 15, "R4 seq wrap 16");
    // R7 interleaved
    burst(16'h00A3, 3'b010, 1'b1, 1'b0, 7, "R7 interleave 8");
    burst(16'h0035, 3'b011, 1'b1, 1'b0, 15, "R7 interleave 16");
    // R8 continuous with rollover at the top
    burst(16'hFFFE, 3'b111, 1'b0, 1'b0, 3, "R8 R11 continuous rollover");
    // R9 illegal combinations; address holds
    cyc(1'b1, 1'b0, 16'h1234, 3'b111, 1'b1, 1'b0, "R9 interleave+continuous");
    cyc(1'b0, 1'b1, '0, 3'b000, 1'b0, 1'b0, "R9 advance after illegal");
    cyc(1'b1, 1'b0, 16'h2222, 3'b001, 1'b1, 1'b1, "R9 interleave+no-wrap");
    cyc(1'b1, 1'b0, 16'h3333, 3'b101, 1'b0, 1'b0, "R9 unused length code");
    cyc(1'b1, 1'b0, 16'h4444, 3'b000, 1'b0, 1'b0, "R9 unused length code 000");
    burst(16'h0050, 3'b001, 1'b0, 1'b0, 1, "R9 legal start clears flag");
    // R2 restart mid-burst with start and advance together
    cyc(1'b1, 1'b1, 16'h0903, 3'b001, 1'b0, 1'b0, "R2 start wins over advance");
    cyc(1'b0, 1'b1, '0, 3'b000, 1'b0, 1'b0, "R2 R4 after restart");
    cyc(1'b0, 1'b0, '0, 3'b000, 1'b0, 1'b0, "R10 marker one cycle");
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule